// File: doc/BRIEF.md
# Programmable down-counting timer

A single down-counter with a small word-addressed register file. The count advances only on cycles where the `tick` clock-enable is high, after passing through a prescaler that divides it by 1, 16 or 256. Software picks one of three counting styles. Free-running wraps at the full counter range. Periodic reloads from a programmable limit. One-shot stops at zero. The counter is 16 or 32 bits wide.

Each time the counter expires, a sticky raw interrupt flag is set. The `irq` output is that flag gated by an enable bit in the control register. The limit can be written in two ways. The immediate path restarts the count from the new value. The deferred path leaves the running count alone and only changes the value used at the next wrap.

A count step that finds the counter at zero is the expiry step. A periodic count from limit N therefore takes N+1 steps per period.

Top module: `tick_down_timer`

## Requirements
- R1: After reset the control register reads 0x20 (interrupt enable only: stopped, free-running, 16-bit). The counter value reads 0, the raw flag reads 0 and `irq` is low.
- R2: Word indices: 0 limit (immediate), 1 counter value, 2 control, 3 interrupt clear, 4 raw flag (bit 0), 5 masked flag (bit 0), 6 limit (deferred). Control bits: 0 one-shot, 1 32-bit width, 3:2 prescale, 5 interrupt enable, 6 periodic, 7 count enable.
- R3: A write to index 0 stores the limit and immediately loads the counter with the reload value for the current mode. Indices 0 and 6 both read back the stored limit.
- R4: A write to index 6 stores the limit without touching the counter value. The new limit is used at the next expiry.
- R5: With the enable bit set, each prescaled step decrements the counter. In periodic mode the step that finds zero reloads the limit and sets the raw flag.
- R6: In one-shot mode (bit 0 set, which overrides periodic), the step that finds zero sets the raw flag and leaves the counter at zero. Counting then stops until a write to index 0, or a control write with the enable bit set.
- R7: In free-running mode (bits 0 and 6 both clear), every reload, whether from a limit write or from an expiry, uses 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode, whatever the stored limit.
- R8: In 16-bit mode only the low 16 bits count and reload. The value register reads with bits 31:16 at zero.
- R9: Prescale code 01 gives one step per 16 ticks and 10 gives one step per 256 ticks. Codes 00 and 11 give one step per tick. The divide phase restarts on every control write, so the first step after the write comes on the 16th or 256th tick.
- R10: The raw flag is set on expiry and cleared by any write to index 3; an expiry in the same cycle wins. The masked flag and `irq` equal the raw flag ANDed with interrupt enable.
- R11: Writes to index 1 and to unmapped index 7 change nothing. Reads of index 7 and of index 3 return 0.
- R12: A control write changes neither the counter value nor the raw flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count clock-enable, fed to the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is 0 when low |
| addr | input | ADDR_W (3) | Register word index |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, combinational from addr |
| irq | output | 1 | Level interrupt, raw flag AND enable |

## Verification
The assertions check the following on every cycle:
- an expiry always leaves the raw flag set on the next cycle;
- a free-running expiry always lands on the full-range value;
- a one-shot expiry parks the counter at zero and disarms it;
- a clear without a simultaneous expiry drops the flag;
- a write to the value register never moves the counter;
- no prescaled step occurs without a tick;
- a masked-status read agrees with `irq`;
- a 16-bit value read has a clear upper half.

Only the bench scenarios can show the exact step counts of each prescale setting and the deferred limit taking effect one wrap later. The same holds for re-arming after a one-shot, and for a control write leaving the count and flag untouched.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  // control field positions (software-visible layout)
  localparam int CB_ONESHOT  = 0;
  localparam int CB_WIDE     = 1;
  localparam int CB_PRE_LO   = 2;
  localparam int CB_IE       = 5;
  localparam int CB_PERIODIC = 6;
  localparam int CB_EN       = 7;
  localparam int CTRL_W      = 8;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  // register word indices
  localparam int IDX_LOAD  = 0;
  localparam int IDX_VALUE = 1;
  localparam int IDX_CTRL  = 2;
  localparam int IDX_CLR   = 3;
  localparam int IDX_RAW   = 4;
  localparam int IDX_MASK  = 5;
  localparam int IDX_BGLD  = 6;
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
  parameter int SLOW_LOG   = 4,
  parameter int SLOWER_LOG = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       restart,
  input  logic [1:0] code,
  output logic       step
);
  localparam int PW = (SLOWER_LOG > SLOW_LOG) ? SLOWER_LOG : SLOW_LOG;

  logic [PW-1:0] phase;

  // true when the current phase closes a divide window for this code
  function automatic logic phase_hit(input logic [1:0] c, input logic [PW-1:0] p);
    logic h;
    case (c)
      2'b01:   h = &p[SLOW_LOG-1:0];
      2'b10:   h = &p[SLOWER_LOG-1:0];
      default: h = 1'b1;
    endcase
    return h;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (tick)    phase <= phase + 1'b1;
  end

  assign step = tick && !restart && phase_hit(code, phase);
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              run_en,
  input  logic              oneshot,
  input  logic              free_mode,
  input  logic              wide,
  input  logic [DATA_W-1:0] limit,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              arm,
  output logic [DATA_W-1:0] value,
  output logic              expire,
  output logic              armed
);
  function automatic logic [DATA_W-1:0] width_mask(input logic w);
    return w ? {DATA_W{1'b1}} : DATA_W'({NARROW_W{1'b1}});
  endfunction

  function automatic logic [DATA_W-1:0] wrap_point(input logic [DATA_W-1:0] lim,
                                                   input logic f, input logic w);
    return f ? width_mask(w) : (lim & width_mask(w));
  endfunction

  logic active;
  assign active = run_en && armed && step;
  assign expire = active && ((value & width_mask(wide)) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
      armed <= 1'b0;
    end else begin
      if (arm)                    armed <= 1'b1;
      else if (expire && oneshot) armed <= 1'b0;

      if (load_wr)     value <= wrap_point(load_data, free_mode, wide);
      else if (expire) value <= oneshot ? '0 : wrap_point(limit, free_mode, wide);
      else if (active) value <= (value - 1'b1) & width_mask(wide);
    end
  end
endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] value,
  input  logic              expire,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] limit_q,
  output logic              raw_q,
  output logic              load_wr,
  output logic              ctrl_wr,
  output logic              arm,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  function automatic logic [DATA_W-1:0] view_value(input logic [DATA_W-1:0] v, input logic w);
    return w ? v : DATA_W'(v[NARROW_W-1:0]);
  endfunction

  logic bg_wr, clr_wr;
  assign load_wr = wr_en && (addr == ADDR_W'(IDX_LOAD));
  assign ctrl_wr = wr_en && (addr == ADDR_W'(IDX_CTRL));
  assign clr_wr  = wr_en && (addr == ADDR_W'(IDX_CLR));
  assign bg_wr   = wr_en && (addr == ADDR_W'(IDX_BGLD));
  assign arm     = load_wr || (ctrl_wr && wdata[CB_EN]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      limit_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (ctrl_wr)              ctrl_q  <= wdata[CTRL_W-1:0];
      if (load_wr || bg_wr)     limit_q <= wdata;
      if (expire)               raw_q   <= 1'b1;
      else if (clr_wr)          raw_q   <= 1'b0;
    end
  end

  assign irq = raw_q && ctrl_q[CB_IE];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        ADDR_W'(IDX_LOAD),
        ADDR_W'(IDX_BGLD):  rdata = limit_q;
        ADDR_W'(IDX_VALUE): rdata = view_value(value, ctrl_q[CB_WIDE]);
        ADDR_W'(IDX_CTRL):  rdata = DATA_W'(ctrl_q);
        ADDR_W'(IDX_RAW):   rdata = DATA_W'(raw_q);
        ADDR_W'(IDX_MASK):  rdata = DATA_W'(irq);
        default:            rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import dtmr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int NARROW_W   = 16,
  parameter int SLOW_LOG   = 4,
  parameter int SLOWER_LOG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] limit_q, value;
  logic raw_q, load_wr, ctrl_wr, arm, step, expire, armed;
  logic oneshot, wide, ie, free_mode;

  assign oneshot   = ctrl_q[CB_ONESHOT];
  assign wide      = ctrl_q[CB_WIDE];
  assign ie        = ctrl_q[CB_IE];
  assign free_mode = !ctrl_q[CB_ONESHOT] && !ctrl_q[CB_PERIODIC];

  dtmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .value(value), .expire(expire), .ctrl_q(ctrl_q),
    .limit_q(limit_q), .raw_q(raw_q), .load_wr(load_wr), .ctrl_wr(ctrl_wr),
    .arm(arm), .rdata(rdata), .irq(irq)
  );

  dtmr_prescaler #(.SLOW_LOG(SLOW_LOG), .SLOWER_LOG(SLOWER_LOG)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(ctrl_wr),
    .code(ctrl_q[CB_PRE_LO+1:CB_PRE_LO]), .step(step)
  );

  dtmr_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .run_en(ctrl_q[CB_EN]),
    .oneshot(oneshot), .free_mode(free_mode), .wide(wide), .limit(limit_q),
    .load_wr(load_wr), .load_data(wdata), .arm(arm), .value(value),
    .expire(expire), .armed(armed)
  );
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker
  import dtmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              step,
  input logic              expire,
  input logic [DATA_W-1:0] value,
  input logic              armed,
  input logic              raw_q,
  input logic              oneshot,
  input logic              free_mode,
  input logic              wide
);
  localparam logic [DATA_W-1:0] NARROW_MAX = DATA_W'({NARROW_W{1'b1}});

  logic load_hit;
  assign load_hit = wr_en && (addr == ADDR_W'(IDX_LOAD));

  AST_EXPIRE_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_q); // R10

  AST_CLEAR_DROPS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(IDX_CLR) && !expire) |=> !raw_q); // R10

  AST_MASKED_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(IDX_MASK)) |-> (rdata[0] == irq)); // R10

  AST_FREE_WRAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && free_mode && !load_hit) |=>
      (value == ($past(wide) ? {DATA_W{1'b1}} : NARROW_MAX))); // R7

  AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && oneshot && !wr_en) |=> (value == '0 && !armed)); // R6

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(IDX_VALUE) && !wide) |-> (rdata[DATA_W-1:NARROW_W] == '0)); // R8

  AST_VALUE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(IDX_VALUE) && !step) |=> $stable(value)); // R11

  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> tick); // R9
endmodule

bind tick_down_timer dtmr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .rdata(rdata), .irq(irq), .step(step), .expire(expire),
  .value(value), .armed(armed), .raw_q(raw_q), .oneshot(oneshot),
  .free_mode(free_mode), .wide(wide)
);

// File: tb/tick_down_timer_tb.sv
module tick_down_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        probe = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  tick_down_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: compares what the design shows against the queued expectation
  always @(negedge clk) begin
    item_t it;
    #2;
    if (rd_en || probe) begin
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: got 0x%08h expected an item", rdata);
      end else begin
        it = sb_q.pop_front();
        if (it.is_irq) begin
          if (irq !== it.exp[0]) begin
            errors++;
            $display("FAIL %s irq: got %0b expected %0b", it.tag, irq, it.exp[0]);
          end
        end else if (rdata !== it.exp) begin
          errors++;
          $display("FAIL %s addr %0d: got 0x%08h expected 0x%08h", it.tag, addr, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    item_t it;
    it.is_irq = 0; it.exp = e; it.tag = t;
    sb_q.push_back(it);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    item_t it;
    it.is_irq = 1; it.exp = {31'd0, e}; it.tag = t;
    sb_q.push_back(it);
    @(negedge clk); probe = 1'b1;
    @(negedge clk); probe = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, 32'h20, "R1 ctrl");
    rd(3'd1, 32'h0,  "R1 value");
    rd(3'd4, 32'h0,  "R1 raw");
    chk_irq(1'b0, "R1");

    // R3 / R5 periodic 32-bit, divide by 1
    wr(3'd2, 32'h62);
    wr(3'd0, 32'd5);
    rd(3'd1, 32'd5, "R3 immediate load");
    rd(3'd0, 32'd5, "R3 limit readback");
    wr(3'd2, 32'hE2);
    rd(3'd1, 32'd5, "R12 value kept on ctrl write");
    ticks(3);
    rd(3'd1, 32'd2, "R5 decrement");
    ticks(2);
    rd(3'd1, 32'd0, "R5 reached zero");
    rd(3'd4, 32'd0, "R10 no flag before expiry step");
    ticks(1);
    rd(3'd1, 32'd5, "R5 periodic reload");
    rd(3'd4, 32'd1, "R10 raw set");
    rd(3'd5, 32'd1, "R10 masked set");
    chk_irq(1'b1, "R10 irq high");
    wr(3'd3, 32'h0);
    rd(3'd4, 32'd0, "R10 raw cleared");
    chk_irq(1'b0, "R10 irq low after clear");

    // R4 deferred limit
    wr(3'd6, 32'd2);
    rd(3'd1, 32'd5, "R4 value untouched");
    rd(3'd6, 32'd2, "R2 deferred limit readback");
    rd(3'd0, 32'd2, "R3 shared limit");
    ticks(6);
    rd(3'd1, 32'd2, "R4 new limit at wrap");
    rd(3'd4, 32'd1, "R10 raw after wrap");

    // R10 / R12 interrupt enable off
    wr(3'd2, 32'hC2);
    rd(3'd4, 32'd1, "R12 raw kept on ctrl write");
    rd(3'd5, 32'd0, "R10 masked off");
    chk_irq(1'b0, "R10 irq masked");
    rd(3'd1, 32'd2, "R12 value kept");

    // R11 ignored accesses
    wr(3'd1, 32'h1234);
    rd(3'd1, 32'd2, "R11 value write ignored");
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd0, 32'd2, "R11 unmapped write limit");
    rd(3'd2, 32'hC2, "R11 unmapped write ctrl");
    rd(3'd7, 32'd0, "R11 unmapped read");
    rd(3'd3, 32'd0, "R11 clear reads zero");

    // R6 one-shot
    wr(3'd3, 32'h0);
    wr(3'd2, 32'hA3);
    wr(3'd0, 32'd3);
    rd(3'd1, 32'd3, "R6 loaded");
    ticks(3);
    rd(3'd1, 32'd0, "R6 at zero");
    rd(3'd4, 32'd0, "R6 no flag yet");
    ticks(1);
    rd(3'd1, 32'd0, "R6 parked at zero");
    rd(3'd4, 32'd1, "R6 flag set");
    wr(3'd3, 32'h0);
    ticks(5);
    rd(3'd4, 32'd0, "R6 stopped, no new flag");
    rd(3'd1, 32'd0, "R6 still zero");
    wr(3'd0, 32'd2);
    ticks(3);
    rd(3'd4, 32'd1, "R6 re-armed by load");

    // R7 / R8 free-running and width
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h60);
    wr(3'd0, 32'h0001_2345);
    rd(3'd1, 32'h2345, "R8 narrow load");
    rd(3'd0, 32'h0001_2345, "R3 full limit stored");
    wr(3'd0, 32'd2);
    wr(3'd2, 32'hA0);
    ticks(3);
    rd(3'd1, 32'hFFFF, "R7 free wrap 16-bit");
    rd(3'd4, 32'd1, "R7 flag on free wrap");
    ticks(2);
    rd(3'd1, 32'hFFFD, "R8 narrow decrement");
    wr(3'd0, 32'd9);
    rd(3'd1, 32'hFFFF, "R7 free load ignores limit");
    rd(3'd0, 32'd9, "R3 limit kept in free mode");
    wr(3'd2, 32'hA2);
    wr(3'd0, 32'd9);
    rd(3'd1, 32'hFFFF_FFFF, "R7 free load 32-bit");
    ticks(1);
    rd(3'd1, 32'hFFFF_FFFE, "R5 32-bit decrement");
    wr(3'd2, 32'hA0);
    rd(3'd1, 32'h0000_FFFE, "R8 upper bits read zero");
    ticks(1);
    rd(3'd1, 32'h0000_FFFD, "R8 only low half counts");

    // R9 prescaler
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h66);
    wr(3'd0, 32'd10);
    wr(3'd2, 32'hE6);
    ticks(15);
    rd(3'd1, 32'd10, "R9 div16 no step before 16th");
    ticks(1);
    rd(3'd1, 32'd9, "R9 div16 step");
    wr(3'd2, 32'hEA);
    ticks(255);
    rd(3'd1, 32'd9, "R9 div256 no step before 256th");
    ticks(1);
    rd(3'd1, 32'd8, "R9 div256 step");
    wr(3'd2, 32'hEE);
    ticks(1);
    rd(3'd1, 32'd7, "R9 code 11 divides by one");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule